// File: doc/BRIEF.md
# Flash Quick-Pulse Program and Erase Sequencer

This block drives a parallel flash array that is controlled by writing command bytes into its command register. A host asks for one of two jobs. The first is a byte program, given an address and a data byte. The second is a whole-array erase. The block then runs the closed-loop pulse-and-verify algorithm by itself, over a plain address / write-data / read-data bus with one-cycle write and read strobes. When the job ends, the block reports a 2-bit result code together with a one-cycle `done` pulse.

A byte program repeats its pulse-and-verify loop until the readback matches the data, up to a pulse limit. An erase works in three steps:
- It first pre-programs 00h into every location, using the same byte loop.
- It then applies erase pulses.
- After each pulse it verifies upward through the array. When a location reads back wrong, the next pulse is followed by a verify that starts again at that same location, not at the bottom of the array.

All delays come from a cycles-per-microsecond parameter. The pulse limits are parameters as well.

Top module: `fqp_seq`

## Requirements
- R1: A byte program writes command 40h, and on the next cycle writes the data byte. The target address is on `fl_addr` throughout. The next write (C0h) happens exactly PROG_US*CYC_PER_US+1 cycles after the data write.
- R2: After the C0h write, the block waits VERIFY_US*CYC_PER_US cycles. It then issues one read at the same address, so the read strobe comes VERIFY_US*CYC_PER_US+1 cycles after the C0h write.
- R3: When the readback differs from the data, the 40h/data/pulse/verify loop repeats. At most MAX_PROG pulses are issued. When the last one still mismatches, the result code is 2 (binary 10).
- R4: An erase first programs 00h into every address from 0 to 2^ADDR_W-1, using the R1–R3 loop. If a location cannot be zeroed within MAX_PROG pulses, the result code is 3 and no erase command (20h) is ever written.
- R5: Each erase pulse is two consecutive write cycles of 20h. A wait of ERASE_US*CYC_PER_US cycles follows, and then A0h is written, ERASE_US*CYC_PER_US+1 cycles after the second 20h.
- R6: After A0h and a wait of VERIFY_US*CYC_PER_US cycles, the block reads one address per cycle, upward, and expects FFh at each. On a mismatch it issues a new erase pulse, and the next verify starts at the failing address.
- R7: If a verify still fails after MAX_ERASE erase pulses, the result code is 1.
- R8: Every job ends with a write of 00h. On the next cycle `done` is high for exactly one cycle and `result` carries the code. Success gives code 0. `result` changes only when `done` rises.
- R9: `busy` is high from the cycle after an accepted start until `done`. Start requests that arrive while `busy` is high are ignored.
- R10: If `start_erase` and `start_prog` are both high in an idle cycle, the erase is started.
- R11: `fl_we` and `fl_re` are never high together, and neither is high while the block is idle.
- R12: After reset, `busy`, `done`, `fl_we` and `fl_re` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | Request a byte program (sampled while idle) |
| start_erase | input | 1 | Request a whole-array erase (sampled while idle) |
| prog_addr | input | ADDR_W | Target address of a byte program |
| prog_data | input | 8 | Data byte of a byte program |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 erase failed, 2 program failed, 3 zeroing failed |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data / command byte |
| fl_rdata | input | 8 | Flash read data, sampled on the edge where `fl_re` is high |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe, one cycle per read |

## Verification
The bench drives the block against a behavioural flash model, and each run uses a different model behaviour.

- **Clean array and good byte.** These runs fix the exact cycle spacing of the command stream and the count of zeroing pulses.
- **Byte that takes a few pulses, and byte stuck high.** Together these separate "retry until match" from "give up at the limit".
- **Stuck byte during an erase.** This shows that a zeroing failure returns code 3 and never reaches an erase command.
- **Location that survives one erase pulse.** The model reports which address is read first after the second erase-verify command, which shows that verification resumes at the failing address and does not restart at zero.
- **Location that survives every pulse.** This exercises the erase-pulse limit.
- **Colliding and overlapping start requests.** These show the erase priority and that a start arriving mid-job is ignored.

// File: rtl/fqp_pkg.sv
package fqp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PCMD,
        S_PDATA,
        S_PPULSE,
        S_PVCMD,
        S_PVWAIT,
        S_PREAD,
        S_ECMD1,
        S_ECMD2,
        S_EPULSE,
        S_EVCMD,
        S_EVWAIT,
        S_EREAD,
        S_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_ERASE = 2'd1,
        RES_PROG  = 2'd2,
        RES_ZERO  = 2'd3
    } res_t;

    localparam logic [7:0] CMD_READ  = 8'h00;
    localparam logic [7:0] CMD_PROG  = 8'h40;
    localparam logic [7:0] CMD_PVER  = 8'hC0;
    localparam logic [7:0] CMD_ERASE = 8'h20;
    localparam logic [7:0] CMD_EVER  = 8'hA0;
    localparam logic [7:0] VAL_ERASED = 8'hFF;
    localparam logic [7:0] VAL_ZERO   = 8'h00;

    typedef struct packed {
        logic       we;
        logic       re;
        logic [7:0] wdata;
    } bus_req_t;

    function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned cpu);
        return us * cpu;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fqp_timer.sv
module fqp_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // expires in the last of the loaded number of waiting cycles
    assign expire = (cnt_q == W'(1));
endmodule

// File: rtl/fqp_walk.sv
module fqp_walk #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          set,
    input  logic          inc,
    input  logic [AW-1:0] set_addr,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr_q <= '0;
        end else if (set) begin
            addr_q <= set_addr;
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = &addr_q;
endmodule

// File: rtl/fqp_tally.sv
module fqp_tally #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && !(&cnt_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/fqp_ctrl.sv
module fqp_ctrl
    import fqp_pkg::*;
#(
    parameter int unsigned TW        = 16,
    parameter int unsigned PW        = 5,
    parameter int unsigned EW        = 10,
    parameter int unsigned PULSE_CYC = 500,
    parameter int unsigned VER_CYC   = 300,
    parameter int unsigned ERASE_CYC = 500000,
    parameter int unsigned MAX_PROG  = 25,
    parameter int unsigned MAX_ERASE = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic [7:0]    prog_data,
    input  logic [7:0]    rdata,
    input  logic          tmr_expire,
    input  logic          walk_last,
    input  logic [PW-1:0] ptry,
    input  logic [EW-1:0] etry,
    output bus_req_t      req,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          walk_clr,
    output logic          walk_set,
    output logic          walk_inc,
    output logic          ptry_clr,
    output logic          ptry_inc,
    output logic          etry_clr,
    output logic          etry_inc,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result
);
    seq_state_t st_q, st_d;
    logic       zeroing_q;
    logic [7:0] data_q;
    res_t       code_q;
    logic       code_set;
    res_t       code_val;
    logic       done_q;
    res_t       result_q;

    always_comb begin
        st_d     = st_q;
        req      = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        walk_clr = 1'b0;
        walk_set = 1'b0;
        walk_inc = 1'b0;
        ptry_clr = 1'b0;
        ptry_inc = 1'b0;
        etry_clr = 1'b0;
        etry_inc = 1'b0;
        code_set = 1'b0;
        code_val = RES_OK;
        unique case (st_q)
            S_IDLE: begin
                if (start_erase) begin
                    st_d     = S_PCMD;
                    walk_clr = 1'b1;
                    ptry_clr = 1'b1;
                    etry_clr = 1'b1;
                end else if (start_prog) begin
                    st_d     = S_PCMD;
                    walk_set = 1'b1;
                    ptry_clr = 1'b1;
                end
            end
            S_PCMD: begin
                req.we    = 1'b1;
                req.wdata = CMD_PROG;
                st_d      = S_PDATA;
            end
            S_PDATA: begin
                req.we    = 1'b1;
                req.wdata = data_q;
                tmr_load  = 1'b1;
                tmr_val   = TW'(PULSE_CYC);
                ptry_inc  = 1'b1;
                st_d      = S_PPULSE;
            end
            S_PPULSE: begin
                if (tmr_expire) st_d = S_PVCMD;
            end
            S_PVCMD: begin
                req.we    = 1'b1;
                req.wdata = CMD_PVER;
                tmr_load  = 1'b1;
                tmr_val   = TW'(VER_CYC);
                st_d      = S_PVWAIT;
            end
            S_PVWAIT: begin
                if (tmr_expire) st_d = S_PREAD;
            end
            S_PREAD: begin
                req.re = 1'b1;
                if (rdata == data_q) begin
                    if (zeroing_q) begin
                        ptry_clr = 1'b1;
                        if (walk_last) begin
                            walk_clr = 1'b1;
                            st_d     = S_ECMD1;
                        end else begin
                            walk_inc = 1'b1;
                            st_d     = S_PCMD;
                        end
                    end else begin
                        st_d = S_FIN;
                    end
                end else if (ptry == PW'(MAX_PROG)) begin
                    code_set = 1'b1;
                    code_val = zeroing_q ? RES_ZERO : RES_PROG;
                    st_d     = S_FIN;
                end else begin
                    st_d = S_PCMD;
                end
            end
            S_ECMD1: begin
                req.we    = 1'b1;
                req.wdata = CMD_ERASE;
                st_d      = S_ECMD2;
            end
            S_ECMD2: begin
                req.we    = 1'b1;
                req.wdata = CMD_ERASE;
                tmr_load  = 1'b1;
                tmr_val   = TW'(ERASE_CYC);
                etry_inc  = 1'b1;
                st_d      = S_EPULSE;
            end
            S_EPULSE: begin
                if (tmr_expire) st_d = S_EVCMD;
            end
            S_EVCMD: begin
                req.we    = 1'b1;
                req.wdata = CMD_EVER;
                tmr_load  = 1'b1;
                tmr_val   = TW'(VER_CYC);
                st_d      = S_EVWAIT;
            end
            S_EVWAIT: begin
                if (tmr_expire) st_d = S_EREAD;
            end
            S_EREAD: begin
                req.re = 1'b1;
                if (rdata == VAL_ERASED) begin
                    if (walk_last) st_d = S_FIN;
                    else           walk_inc = 1'b1;
                end else if (etry == EW'(MAX_ERASE)) begin
                    code_set = 1'b1;
                    code_val = RES_ERASE;
                    st_d     = S_FIN;
                end else begin
                    st_d = S_ECMD1;
                end
            end
            S_FIN: begin
                req.we    = 1'b1;
                req.wdata = CMD_READ;
                st_d      = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            zeroing_q <= 1'b0;
            data_q    <= '0;
            code_q    <= RES_OK;
            done_q    <= 1'b0;
            result_q  <= RES_OK;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == S_FIN);
            if (st_q == S_FIN) result_q <= code_q;
            if (st_q == S_IDLE && start_erase) begin
                zeroing_q <= 1'b1;
                data_q    <= VAL_ZERO;
                code_q    <= RES_OK;
            end else if (st_q == S_IDLE && start_prog) begin
                zeroing_q <= 1'b0;
                data_q    <= prog_data;
                code_q    <= RES_OK;
            end else begin
                if (st_d == S_ECMD1) zeroing_q <= 1'b0;
                if (code_set) code_q <= code_val;
            end
        end
    end

    assign busy   = (st_q != S_IDLE);
    assign done   = done_q;
    assign result = result_q;
endmodule

// File: rtl/fqp_seq.sv
module fqp_seq
    import fqp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned CYC_PER_US = 50,
    parameter int unsigned PROG_US    = 10,
    parameter int unsigned VERIFY_US  = 6,
    parameter int unsigned ERASE_US   = 10000,
    parameter int unsigned MAX_PROG   = 25,
    parameter int unsigned MAX_ERASE  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              fl_we,
    output logic              fl_re
);
    localparam int unsigned PULSE_CYC = us_to_cyc(PROG_US, CYC_PER_US);
    localparam int unsigned VER_CYC   = us_to_cyc(VERIFY_US, CYC_PER_US);
    localparam int unsigned ERASE_CYC = us_to_cyc(ERASE_US, CYC_PER_US);
    localparam int unsigned TW = cnt_bits(max3(PULSE_CYC, VER_CYC, ERASE_CYC));
    localparam int unsigned PW = cnt_bits(MAX_PROG);
    localparam int unsigned EW = cnt_bits(MAX_ERASE);

    bus_req_t      req;
    logic          tmr_load, tmr_expire;
    logic [TW-1:0] tmr_val;
    logic          walk_clr, walk_set, walk_inc, walk_last;
    logic          ptry_clr, ptry_inc, etry_clr, etry_inc;
    logic [PW-1:0] ptry;
    logic [EW-1:0] etry;

    fqp_ctrl #(
        .TW(TW), .PW(PW), .EW(EW),
        .PULSE_CYC(PULSE_CYC), .VER_CYC(VER_CYC), .ERASE_CYC(ERASE_CYC),
        .MAX_PROG(MAX_PROG), .MAX_ERASE(MAX_ERASE)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .start_prog(start_prog), .start_erase(start_erase),
        .prog_data(prog_data), .rdata(fl_rdata),
        .tmr_expire(tmr_expire), .walk_last(walk_last),
        .ptry(ptry), .etry(etry),
        .req(req), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .walk_clr(walk_clr), .walk_set(walk_set), .walk_inc(walk_inc),
        .ptry_clr(ptry_clr), .ptry_inc(ptry_inc),
        .etry_clr(etry_clr), .etry_inc(etry_inc),
        .busy(busy), .done(done), .result(result)
    );

    fqp_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .expire(tmr_expire)
    );

    fqp_walk #(.AW(ADDR_W)) u_walk (
        .clk(clk), .rst(rst), .clr(walk_clr), .set(walk_set), .inc(walk_inc),
        .set_addr(prog_addr), .addr(fl_addr), .last(walk_last)
    );

    fqp_tally #(.W(PW)) u_ptry (
        .clk(clk), .rst(rst), .clr(ptry_clr), .inc(ptry_inc), .count(ptry)
    );

    fqp_tally #(.W(EW)) u_etry (
        .clk(clk), .rst(rst), .clr(etry_clr), .inc(etry_inc), .count(etry)
    );

    assign fl_we    = req.we;
    assign fl_re    = req.re;
    assign fl_wdata = req.wdata;
endmodule

// File: rtl/fqp_chk.sv
module fqp_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_prog,
    input logic       start_erase,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic [7:0] fl_wdata,
    input logic       fl_we,
    input logic       fl_re
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> (!fl_we && !fl_re));

    // R8
    done_after_read_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(fl_we) && $past(fl_wdata) == 8'h00));

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R9
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_prog || start_erase));

    // R8
    result_held_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R1
    prog_cmd_then_data_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_we && fl_wdata == 8'h40 && !$past(fl_we)) |=> fl_we);

    // R5
    erase_cmd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_we && fl_wdata == 8'h20 && !($past(fl_we) && $past(fl_wdata) == 8'h20))
        |=> (fl_we && fl_wdata == 8'h20));
endmodule

bind fqp_seq fqp_chk u_chk (
    .clk(clk), .rst(rst),
    .start_prog(start_prog), .start_erase(start_erase),
    .busy(busy), .done(done), .result(result),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/sim_fqp_seq.sv
module sim_fqp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 3;
    localparam int DEPTH = 8;
    localparam int PULSE = 10;
    localparam int VER   = 6;
    localparam int ERA   = 40;
    localparam int MAXP  = 25;
    localparam int MAXE  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_prog = 1'b0, start_erase = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [7:0]    prog_data = '0;
    logic          busy, done;
    logic [1:0]    result;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          fl_we, fl_re;

    always #(CLK_PERIOD/2) clk = ~clk;

    fqp_seq #(
        .ADDR_W(AW), .CYC_PER_US(1), .PROG_US(PULSE), .VERIFY_US(VER),
        .ERASE_US(ERA), .MAX_PROG(MAXP), .MAX_ERASE(MAXE)
    ) u0 (
        .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
        .prog_addr(prog_addr), .prog_data(prog_data), .busy(busy), .done(done),
        .result(result), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_we(fl_we), .fl_re(fl_re)
    );

    // ---------------- behavioural flash model ----------------
    logic [7:0] mem [DEPTH];
    assign fl_rdata = mem[fl_addr];

    int mode, cyc, ptotal, etotal, t_prev_we, t_vcmd;
    int gap20, gap_er, gap_pg, gap_ver, rd_after_a0, overlap;
    logic ver_pend, a0_pend;
    logic [7:0] last_wd;
    // fault controls, written by the test tasks only
    logic stuck_en = 1'b0;
    int   stuck_a = 0, slow_a = -1, slow_n = 0, pbase = 0;
    int   ebad = 0, ebase = 0, ebad_a = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] = 8'h5A;
            mode = 0; cyc = 0; ptotal = 0; etotal = 0; t_prev_we = 0; t_vcmd = 0;
            gap20 = -1; gap_er = -1; gap_pg = -1; gap_ver = -1; rd_after_a0 = -1;
            overlap = 0; ver_pend = 1'b0; a0_pend = 1'b0; last_wd = 8'hEE;
        end else begin
            if (fl_we && fl_re) overlap++;
            if (fl_re && ver_pend) begin gap_ver = cyc - t_vcmd; ver_pend = 1'b0; end
            if (fl_re && a0_pend) begin rd_after_a0 = int'(fl_addr); a0_pend = 1'b0; end
            if (fl_we) begin
                if (mode == 1) begin
                    if (!(stuck_en && int'(fl_addr) == stuck_a) &&
                        !(int'(fl_addr) == slow_a && (ptotal - pbase) <= slow_n))
                        mem[fl_addr] = mem[fl_addr] & fl_wdata;
                    mode = 0;
                end else begin
                    case (fl_wdata)
                        8'h40: begin mode = 1; ptotal++; end
                        8'h20: begin
                            if (mode == 2) begin
                                gap20 = cyc - t_prev_we;
                                for (int i = 0; i < DEPTH; i++)
                                    if (!((etotal - ebase) < ebad && i == ebad_a)) mem[i] = 8'hFF;
                                etotal++;
                                mode = 0;
                            end else begin
                                mode = 2;
                            end
                        end
                        8'hA0: begin
                            gap_er = cyc - t_prev_we; t_vcmd = cyc;
                            ver_pend = 1'b1; a0_pend = 1'b1; mode = 3;
                        end
                        8'hC0: begin
                            gap_pg = cyc - t_prev_we; t_vcmd = cyc;
                            ver_pend = 1'b1; mode = 4;
                        end
                        default: mode = 0;
                    endcase
                end
                last_wd = fl_wdata;
                t_prev_we = cyc;
            end
            cyc++;
        end
    end

    // ---------------- checking infrastructure ----------------
    int n_chk = 0, n_fail = 0;
    logic finished = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(req, "done reached", int'(done), 1);
        @(negedge clk);
        chk(req, "done one cycle", int'(done), 0);
    endtask

    task automatic launch(input bit p, input bit e, input int a, input int d, output int busy_seen);
        @(negedge clk);
        start_prog  = p;
        start_erase = e;
        prog_addr   = AW'(a);
        prog_data   = 8'(d);
        @(negedge clk);
        start_prog  = 1'b0;
        start_erase = 1'b0;
        busy_seen   = int'(busy);
    endtask

    function automatic int not_ff();
        int c = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'hFF) c++;
        return c;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R12", "busy", int'(busy), 0);
        chk("R12", "done", int'(done), 0);
        chk("R12", "result", int'(result), 0);
        chk("R12", "strobes", int'(fl_we) + int'(fl_re), 0);
    endtask

    task automatic t_erase_clean();
        int p0, e0, b;
        p0 = ptotal; e0 = etotal;
        launch(1'b0, 1'b1, 0, 0, b);
        chk("R9", "busy after start", b, 1);
        wait_done("R8");
        chk("R4", "zeroing pulses", ptotal - p0, DEPTH);
        chk("R5", "erase pulses", etotal - e0, 1);
        chk("R5", "20h pair spacing", gap20, 1);
        chk("R5", "erase pulse wait", gap_er, ERA + 1);
        chk("R6", "non-FF bytes", not_ff(), 0);
        chk("R8", "result ok", int'(result), 0);
        chk("R8", "final read cmd", int'(last_wd), 0);
    endtask

    task automatic t_prog_ok();
        int p0, b;
        p0 = ptotal;
        launch(1'b1, 1'b0, 3, 8'hA5, b);
        wait_done("R1");
        chk("R1", "byte written", int'(mem[3]), 8'hA5);
        chk("R1", "program pulse wait", gap_pg, PULSE + 1);
        chk("R2", "verify wait", gap_ver, VER + 1);
        chk("R3", "single pulse", ptotal - p0, 1);
        chk("R8", "result ok", int'(result), 0);
    endtask

    task automatic t_prog_retry();
        int b;
        pbase = ptotal; slow_a = 6; slow_n = 4;
        launch(1'b1, 1'b0, 6, 8'h3C, b);
        wait_done("R3");
        chk("R3", "retry pulses", ptotal - pbase, 5);
        chk("R3", "retry result", int'(result), 0);
        chk("R3", "retry byte", int'(mem[6]), 8'h3C);
        slow_a = -1;
    endtask

    task automatic t_prog_fail();
        int p0, b;
        p0 = ptotal; stuck_en = 1'b1; stuck_a = 2;
        launch(1'b1, 1'b0, 2, 8'h00, b);
        wait_done("R3");
        chk("R3", "pulse limit", ptotal - p0, MAXP);
        chk("R3", "program fail code", int'(result), 2);
        chk("R8", "final read cmd", int'(last_wd), 0);
    endtask

    task automatic t_zero_fail();
        int p0, e0, b;
        p0 = ptotal; e0 = etotal;
        launch(1'b0, 1'b1, 0, 0, b);
        wait_done("R4");
        chk("R4", "zeroing fail code", int'(result), 3);
        chk("R4", "no erase pulse", etotal - e0, 0);
        chk("R4", "zeroing pulses", ptotal - p0, 2 + MAXP);
        stuck_en = 1'b0;
    endtask

    task automatic t_erase_resume();
        int e0, b;
        e0 = etotal; ebase = etotal; ebad = 1; ebad_a = 5;
        launch(1'b0, 1'b1, 0, 0, b);
        wait_done("R6");
        chk("R6", "erase pulses", etotal - e0, 2);
        chk("R6", "verify resume addr", rd_after_a0, 5);
        chk("R6", "result ok", int'(result), 0);
        chk("R6", "non-FF bytes", not_ff(), 0);
        ebad = 0;
    endtask

    task automatic t_erase_fail();
        int e0, b;
        e0 = etotal; ebase = etotal; ebad = 10; ebad_a = 5;
        launch(1'b0, 1'b1, 0, 0, b);
        wait_done("R7");
        chk("R7", "erase pulse limit", etotal - e0, MAXE);
        chk("R7", "erase fail code", int'(result), 1);
        chk("R8", "final read cmd", int'(last_wd), 0);
        ebad = 0;
    endtask

    task automatic t_busy_ignore();
        int p0, e0, b;
        p0 = ptotal; e0 = etotal;
        launch(1'b1, 1'b0, 1, 8'h11, b);
        chk("R9", "busy after start", b, 1);
        repeat (3) @(negedge clk);
        start_erase = 1'b1; start_prog = 1'b1; prog_addr = 3'd4; prog_data = 8'h00;
        @(negedge clk);
        start_erase = 1'b0; start_prog = 1'b0;
        chk("R9", "busy held", int'(busy), 1);
        wait_done("R9");
        chk("R9", "first job byte", int'(mem[1]), 8'h11);
        chk("R9", "ignored job byte", int'(mem[4]), 8'hFF);
        chk("R9", "no erase started", etotal - e0, 0);
        chk("R9", "one pulse only", ptotal - p0, 1);
    endtask

    task automatic t_both_start();
        int p0, e0, b;
        p0 = ptotal; e0 = etotal;
        launch(1'b1, 1'b1, 0, 8'h12, b);
        wait_done("R10");
        chk("R10", "erase taken", etotal - e0, 1);
        chk("R10", "zeroing pulses", ptotal - p0, DEPTH);
        chk("R10", "byte erased", int'(mem[0]), 8'hFF);
        chk("R10", "result ok", int'(result), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_erase_clean();
        t_prog_ok();
        t_prog_retry();
        t_prog_fail();
        t_zero_fail();
        t_erase_resume();
        t_erase_fail();
        t_busy_ignore();
        t_both_start();
        chk("R11", "strobe overlap cycles", overlap, 0);
        finish_run();
    end
endmodule